// File: doc/BRIEF.md
# Keyed Watchdog with Two-Stage Expiry

This block guards a system against a stalled processor. Software programs it through one 32-bit control word that holds a reload count, an enable command and a 7-bit key. Once the watchdog is enabled, each new control write must carry the bitwise complement of the key stored by the previous accepted write. A write with any other key is dropped. This makes it unlikely that a stray store from runaway code restarts or stops the watchdog.

The counter steps down on a slow tick-enable input, nominally about 760 Hz, which is generated outside the block. The first time the count runs out, the block raises a non-maskable interrupt and reloads a short grace count. If software still does not service the watchdog and the grace count also runs out, the block pulses a reset request for one clock cycle. It then returns to the disabled state with the stored control word cleared. A status word reports the live count and the expiry stage.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, `nmi` and `sys_rst_req` are low, the control word reads back as 0 and the status word reads back as 0.
- R2: While bit 8 of the stored control word (enable) is 0, every control write is accepted, whatever its key in bits [15:9].
- R3: While the stored enable bit is 1, a control write whose key bits [15:9] are not the 7-bit complement of the stored key has no effect. The stored word, the count, the running state and `nmi` are all unchanged.
- R4: An accepted control write with bit 8 set loads the counter from bits [8:0] and starts counting. Because bit 8 is shared, the loaded count is always at least 256.
- R5: An accepted control write with bit 8 clear stops the counter, and the count holds its value from then on, even while ticks arrive.
- R6: While running, the count drops by exactly one on each clock cycle with `tick` high and does not change otherwise.
- R7: In the first stage, a tick that arrives while the count is 1 or 0 raises `nmi` and reloads the count with GRACE_TICKS (default 10). The watchdog stays running.
- R8: In the grace stage, a tick that arrives while the count is 1 or 0 drives `sys_rst_req` high for exactly one cycle. At the same edge, `nmi` drops, the count and the stored control word go to 0, and the watchdog is disabled.
- R9: An accepted control write lowers `nmi` and returns the block to the first stage.
- R10: Reads are registered and return data one cycle after `bus_rd`. Offset 0x40 returns the full stored 32-bit control word. Offset 0x44 returns the count in [8:0], running in [9] and the grace stage in [10], with zeros above. Any other offset returns 0.
- R11: When a control write and a tick arrive in the same cycle, the write takes effect and the tick is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count-enable strobe from the external tick generator |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| nmi | output | 1 | Non-maskable interrupt, high in the grace stage |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
- **Writes:** A control write takes effect at the clock edge that samples it, so the next read observes the new stored word and count.
- **Reads:** Read data is registered and appears one cycle after `bus_rd`.
- **Expiry outputs:** `nmi` and `sys_rst_req` are flops. Each one changes at the same edge that samples the expiring tick.
- **Bench timing:** The bench drives every stimulus at the falling edge and samples at the following falling edge. Each sample therefore falls exactly one register stage after its cause.
- **Tick scenarios:** Ticks are given as counted runs, so the expected count is always known exactly. The cycle that carries the final tick is checked for the reset pulse, and the cycle after it is checked for the pulse's end.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam int DATA_W  = 32;
  localparam int CNT_W   = 9;
  localparam int KEY_W   = 7;
  localparam int EN_BIT  = 8;
  localparam int KEY_LSB = CNT_W;

  typedef enum logic [1:0] {
    WD_IDLE  = 2'd0,
    WD_ARMED = 2'd1,
    WD_GRACE = 2'd2
  } wd_stage_e;

  function automatic logic [KEY_W-1:0] key_field(input logic [DATA_W-1:0] w);
    return w[KEY_LSB +: KEY_W];
  endfunction
endpackage

// File: rtl/kwd_keygate.sv
module kwd_keygate
  import kwd_pkg::*;
(
  input  logic              wr_ctrl,
  input  logic [DATA_W-1:0] new_word,
  input  logic [DATA_W-1:0] held_word,
  output logic              accept
);
  logic              guarded;
  logic [KEY_W-1:0]  want_key;

  always_comb begin
    guarded  = held_word[EN_BIT];
    want_key = ~key_field(held_word);
    accept   = wr_ctrl && (!guarded || (key_field(new_word) == want_key));
  end
endmodule

// File: rtl/kwd_counter.sv
module kwd_counter
  import kwd_pkg::*;
#(
  parameter int GRACE_TICKS = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             cmd,
  input  logic             cmd_run,
  input  logic [CNT_W-1:0] cmd_count,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic             in_grace,
  output logic             final_hit,
  output logic             nmi,
  output logic             rst_pulse
);
  localparam logic [CNT_W-1:0] GRACE_VAL = CNT_W'(GRACE_TICKS);

  wd_stage_e stage_q;
  logic      run_out;

  always_comb begin
    run_out   = tick && (stage_q != WD_IDLE) && (count <= CNT_W'(1)) && !cmd;
    final_hit = run_out && (stage_q == WD_GRACE);
    running   = (stage_q != WD_IDLE);
    in_grace  = (stage_q == WD_GRACE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q   <= WD_IDLE;
      count     <= '0;
      nmi       <= 1'b0;
      rst_pulse <= 1'b0;
    end else begin
      rst_pulse <= 1'b0;
      if (cmd) begin
        nmi <= 1'b0;
        if (cmd_run) begin
          stage_q <= WD_ARMED;
          count   <= cmd_count;
        end else begin
          stage_q <= WD_IDLE;
        end
      end else if (run_out) begin
        if (stage_q == WD_ARMED) begin
          stage_q <= WD_GRACE;
          count   <= GRACE_VAL;
          nmi     <= 1'b1;
        end else begin
          stage_q   <= WD_IDLE;
          count     <= '0;
          nmi       <= 1'b0;
          rst_pulse <= 1'b1;
        end
      end else if (tick && stage_q != WD_IDLE) begin
        count <= count - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import kwd_pkg::*;
#(
  parameter int              GRACE_TICKS = 10,
  parameter int              ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFFS = 8'h40,
  parameter logic [ADDR_W-1:0] STAT_OFFS = 8'h44
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              nmi,
  output logic              sys_rst_req
);
  localparam int STAT_PAD = DATA_W - CNT_W - 2;

  logic [DATA_W-1:0] ctrl_q;
  logic              wr_ctrl;
  logic              accept;
  logic [CNT_W-1:0]  cnt_q;
  logic              running;
  logic              in_grace;
  logic              final_hit;
  logic [DATA_W-1:0] stat_word;

  assign wr_ctrl   = bus_wr && (bus_addr == CTRL_OFFS);
  assign stat_word = {{STAT_PAD{1'b0}}, in_grace, running, cnt_q};

  kwd_keygate u_gate (
    .wr_ctrl   (wr_ctrl),
    .new_word  (bus_wdata),
    .held_word (ctrl_q),
    .accept    (accept)
  );

  kwd_counter #(.GRACE_TICKS(GRACE_TICKS)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .cmd       (accept),
    .cmd_run   (bus_wdata[EN_BIT]),
    .cmd_count (bus_wdata[CNT_W-1:0]),
    .count     (cnt_q),
    .running   (running),
    .in_grace  (in_grace),
    .final_hit (final_hit),
    .nmi       (nmi),
    .rst_pulse (sys_rst_req)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (accept) begin
      ctrl_q <= bus_wdata;
    end else if (final_hit) begin
      ctrl_q <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (bus_addr == CTRL_OFFS)      bus_rdata <= ctrl_q;
      else if (bus_addr == STAT_OFFS) bus_rdata <= stat_word;
      else                            bus_rdata <= '0;
    end
  end
endmodule

// File: rtl/kwd_checker.sv
module kwd_checker
  import kwd_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              wr_ctrl,
  input logic              accept,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] ctrl_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              nmi,
  input logic              sys_rst_req
);
  p_rst_single_r8: assert property (@(posedge clk) disable iff (rst)
    sys_rst_req |=> !sys_rst_req);

  p_rst_from_grace_r8: assert property (@(posedge clk) disable iff (rst)
    sys_rst_req |-> (!nmi && ctrl_q == '0 && $past(nmi)));

  p_nmi_on_tick_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(nmi) |-> ($past(tick) && !$past(wr_ctrl)));

  p_bad_key_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && ctrl_q[EN_BIT] && key_field(wdata) != ~key_field(ctrl_q) && !tick)
      |=> ($stable(ctrl_q) && $stable(cnt_q) && $stable(nmi)));

  p_load_r4: assert property (@(posedge clk) disable iff (rst)
    (accept && wdata[EN_BIT]) |=> (cnt_q == $past(wdata[CNT_W-1:0])));

  p_nmi_clear_r9: assert property (@(posedge clk) disable iff (rst)
    accept |=> !nmi);

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!tick && !wr_ctrl) |=> $stable(cnt_q));
endmodule

bind keyed_watchdog kwd_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .tick        (tick),
  .wr_ctrl     (wr_ctrl),
  .accept      (accept),
  .wdata       (bus_wdata),
  .ctrl_q      (ctrl_q),
  .cnt_q       (cnt_q),
  .nmi         (nmi),
  .sys_rst_req (sys_rst_req)
);

// File: tb/keyed_watchdog_bench.sv
module keyed_watchdog_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        nmi;
  logic        sys_rst_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  keyed_watchdog u_keyed_watchdog (
    .clk(clk), .rst(rst), .tick(tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .nmi(nmi), .sys_rst_req(sys_rst_req)
  );

  localparam logic [7:0] A_CTRL = 8'h40;
  localparam logic [7:0] A_STAT = 8'h44;

  function automatic logic [31:0] cw(input logic [6:0] key, input logic en, input logic [7:0] low);
    return {16'h0, key, en, low};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic tk = 1'b0);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; tick = tk;
    @(negedge clk);
    bus_wr = 1'b0; tick = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
    end
    tick = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 nmi", {31'h0, nmi}, 32'h0);
    check("R1 rst_req", {31'h0, sys_rst_req}, 32'h0);
    rd(A_CTRL, d); check("R1 ctrl", d, 32'h0);
    rd(A_STAT, d); check("R1 stat", d, 32'h0);
  endtask

  task automatic t_disabled_keys;
    logic [31:0] d;
    wr(A_CTRL, 32'hABCD_0000 | cw(7'h05, 1'b0, 8'h03));
    rd(A_CTRL, d); check("R2 any key while disabled / R10 full word", d, 32'hABCD_0A03);
    wr(A_CTRL, cw(7'h7F, 1'b0, 8'h00));
    rd(A_CTRL, d); check("R2 second key while disabled", d, 32'h0000_FE00);
  endtask

  task automatic t_enable_and_count;
    logic [31:0] d;
    wr(A_CTRL, cw(7'h11, 1'b1, 8'h20));
    rd(A_STAT, d); check("R4 load 0x120 / R10 status", d, 32'h320);
    ticks(5);
    rd(A_STAT, d); check("R6 five ticks", d, 32'h31B);
    repeat (4) @(negedge clk);
    rd(A_STAT, d); check("R6 no tick hold", d, 32'h31B);
  endtask

  task automatic t_bad_key;
    logic [31:0] d;
    wr(A_CTRL, cw(7'h11, 1'b1, 8'h05));
    rd(A_CTRL, d); check("R3 same key ignored ctrl", d, 32'h2320);
    rd(A_STAT, d); check("R3 same key ignored count", d, 32'h31B);
    wr(A_CTRL, cw(7'h12, 1'b0, 8'h00));
    rd(A_STAT, d); check("R3 bad key stop ignored", d, 32'h31B);
  endtask

  task automatic t_reload_stop;
    logic [31:0] d;
    wr(A_CTRL, cw(7'h6E, 1'b1, 8'h04));
    rd(A_STAT, d); check("R4 good key reload", d, 32'h304);
    wr(A_CTRL, cw(7'h11, 1'b0, 8'h00));
    rd(A_STAT, d); check("R5 stop", d, 32'h104);
    ticks(3);
    rd(A_STAT, d); check("R5 stopped ignores ticks", d, 32'h104);
  endtask

  task automatic t_expiry;
    logic [31:0] d;
    wr(A_CTRL, cw(7'h22, 1'b1, 8'h00));
    ticks(255);
    rd(A_STAT, d); check("R6 count at 1", d, 32'h201);
    check("R7 no nmi yet", {31'h0, nmi}, 32'h0);
    ticks(1);
    check("R7 nmi raised", {31'h0, nmi}, 32'h1);
    rd(A_STAT, d); check("R7 grace reload", d, 32'h60A);
    ticks(9);
    check("R8 no reset before grace ends", {31'h0, sys_rst_req}, 32'h0);
    ticks(1);
    check("R8 reset pulse", {31'h0, sys_rst_req}, 32'h1);
    check("R8 nmi drops", {31'h0, nmi}, 32'h0);
    @(negedge clk);
    check("R8 pulse one cycle", {31'h0, sys_rst_req}, 32'h0);
    rd(A_CTRL, d); check("R8 ctrl cleared", d, 32'h0);
    rd(A_STAT, d); check("R8 disabled", d, 32'h0);
  endtask

  task automatic t_nmi_clear;
    logic [31:0] d;
    wr(A_CTRL, cw(7'h01, 1'b1, 8'h00));
    ticks(256);
    check("R7 nmi second run", {31'h0, nmi}, 32'h1);
    wr(A_CTRL, cw(7'h01, 1'b1, 8'h00));
    check("R3 bad key keeps nmi", {31'h0, nmi}, 32'h1);
    wr(A_CTRL, cw(7'h7E, 1'b1, 8'h50));
    check("R9 nmi cleared", {31'h0, nmi}, 32'h0);
    rd(A_STAT, d); check("R9 stage back to first", d, 32'h350);
  endtask

  task automatic t_collision;
    logic [31:0] d;
    wr(A_CTRL, cw(7'h01, 1'b1, 8'h07), 1'b1);
    rd(A_STAT, d); check("R11 write beats tick", d, 32'h307);
    rd(8'h48, d); check("R10 unmapped reads 0", d, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog timeout actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_disabled_keys();
    t_enable_and_count();
    t_bad_key();
    t_reload_stop();
    t_expiry();
    t_nmi_clear();
    t_collision();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule